// File: doc/BRIEF.md
# Interrupt Distributor

This block collects interrupt lines from peripherals, holds a pending state for each one, and offers every CPU interface the most urgent interrupt that is enabled, pending, not already being serviced and aimed at that CPU. Each interrupt ID has an enable bit, a trigger kind (level-high or rising-edge), an 8-bit priority and, for shared IDs, an 8-bit CPU target mask. Software programs all of this over a plain 32-bit word bus. The bus has a write strobe, a word address and a read port whose value is always valid for the current address. Software can also raise software interrupts for a chosen set of CPUs.

IDs 0 to 15 are software interrupts, with one pending bit per CPU. IDs 16 to 31 are private lines that go to every CPU. IDs 32 and up are shared lines that go to the CPUs named in their target byte. Peripheral line k of `irq_in` is interrupt ID k+16. The CPU-side logic in the next block returns an acknowledge pulse when it takes an interrupt and an end-of-interrupt pulse when it finishes. Between those two pulses the ID is active and is not offered again.

Word addresses: control 0x000, type 0x001, enable-set 0x040 plus ID/32, enable-clear 0x060 plus ID/32, priority 0x100 plus ID/4, target 0x200 plus ID/4, trigger 0x300 plus ID/16, software interrupt 0x3C0. In each 32-bit word, bit ID%32 is the enable bit, byte ID%4 is the priority or target byte, and bit 2·(ID%16)+1 is the trigger bit.

Top module: `irq_distributor`

## Requirements
- R1: A write with bit b set to enable-set word w enables ID 32w+b. The same bit in enable-clear word w disables it. Zero bits change nothing. Reading either bank returns the current enable bits. All enables are 0 after reset.
- R2: Trigger bit 2·(ID%16)+1 of trigger word ID/16 selects rising edge (1) or level-high (0). Even bits read 0. IDs 0–15 always read as edge (word 0x300 reads 0xAAAAAAAA) and ignore writes. All other IDs reset to level.
- R3: Priority byte ID%4 of word 0x100+ID/4 and target byte ID%4 of word 0x200+ID/4 can be written and read back for every ID from 32 up.
- R4: Control bit 0 (reset 0) enables forwarding. While it is 0, no `fwd_valid` bit is set.
- R5: The type word reads (N/32 − 1) in bits [4:0] and 0 elsewhere, and ignores writes.
- R6: A write to the software-interrupt word with CPU mask in bits [23:16] and ID in bits [3:0] makes that ID pending for each CPU whose mask bit is set.
- R7: Target words for IDs 0–31 read the one-hot mask of the reading CPU (`bus_cpu`) in every byte, and ignore writes.
- R8: An edge interrupt becomes pending on a 0→1 input transition and stays pending after the input falls, until it is acknowledged. Acknowledging clears it, and it does not come back without a new edge.
- R9: A level interrupt is pending while its input is high and the ID is not active.
- R10: Among the candidates for a CPU, the lowest priority value wins. On a tie, the lower ID wins. `fwd_prio` carries the winner's priority.
- R11: A shared ID goes only to CPUs whose bit is set in its target byte. A software interrupt goes only to CPUs it was raised for.
- R12: Unimplemented word addresses read 0 and ignore writes.
- R13: An acknowledge makes the ID active, and it is not forwarded to any CPU until an end-of-interrupt for that ID clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N-16 | Peripheral lines; bit k is ID k+16 |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW-2 | Word address (byte address bits AW-1:2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| bus_cpu | input | log2(NCPU) | Index of the CPU making the access |
| ack_stb | input | NCPU | Per-CPU acknowledge pulse |
| ack_id | input | 10·NCPU | Acknowledged ID per CPU |
| eoi_stb | input | NCPU | Per-CPU end-of-interrupt pulse |
| eoi_id | input | 10·NCPU | Completed ID per CPU |
| fwd_valid | output | NCPU | An interrupt is offered to CPU c |
| fwd_id | output | 10·NCPU | Offered ID per CPU |
| fwd_prio | output | 8·NCPU | Priority of the offered ID per CPU |

## Verification
The hardest case to reach is a software interrupt that two CPUs hold pending at once, while one CPU's acknowledge makes the shared ID active. The stimulus raises one software interrupt for CPU 1 alone, then a second one for both CPUs. It acknowledges the second from CPU 1 and checks that CPU 0 loses the offer while CPU 1 falls back to the other ID. An end-of-interrupt then brings the offer back to CPU 0. Edge capture is reached with a single-cycle input pulse, so that the pending state is seen only after the line has dropped again.

// File: rtl/irq_distributor.sv
module irq_distributor #(
  parameter int N    = 64,
  parameter int NCPU = 2,
  parameter int AW   = 12
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [N-17:0]                         irq_in,
  input  logic                                  bus_wr,
  input  logic [AW-1:2]                         bus_addr,
  input  logic [31:0]                           bus_wdata,
  output logic [31:0]                           bus_rdata,
  input  logic [(NCPU>1?$clog2(NCPU):1)-1:0]    bus_cpu,
  input  logic [NCPU-1:0]                       ack_stb,
  input  logic [NCPU*10-1:0]                    ack_id,
  input  logic [NCPU-1:0]                       eoi_stb,
  input  logic [NCPU*10-1:0]                    eoi_id,
  output logic [NCPU-1:0]                       fwd_valid,
  output logic [NCPU*10-1:0]                    fwd_id,
  output logic [NCPU*8-1:0]                     fwd_prio
);
  localparam int NW     = N / 32;
  localparam int NSPI   = N - 32;
  localparam int NEXT   = N - 16;
  localparam int W_CTL  = 0;
  localparam int W_TYPE = 1;
  localparam int W_ESET = 'h40;
  localparam int W_ECLR = 'h60;
  localparam int W_PRIO = 'h100;
  localparam int W_TGT  = 'h200;
  localparam int W_CFG  = 'h300;
  localparam int W_SOFT = 'h3C0;

  logic                      ctl_q;
  logic [N-1:0]              ena_q, act_q;
  logic [N-1:0][7:0]         prio_q;
  logic [NSPI-1:0][7:0]      tgt_q;
  logic [NEXT-1:0]           cfg_q, epend_q, irq_q, pend_ext;
  logic [NCPU-1:0][15:0]     sgi_q;
  logic [NCPU-1:0][N-1:0]    cand;
  logic [NCPU-1:0]           bv;
  logic [NCPU-1:0][7:0]      bp;
  logic [NCPU-1:0][9:0]      bi;
  logic [31:0]               wa;
  logic [7:0]                own_mask;

  assign wa       = 32'(bus_addr);
  assign own_mask = 8'd1 << bus_cpu;

  always_comb
    for (int j = 0; j < NEXT; j++)
      pend_ext[j] = cfg_q[j] ? epend_q[j] : (irq_in[j] & ~act_q[j+16]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= 1'b0;
      ena_q   <= '0;
      act_q   <= '0;
      prio_q  <= '0;
      tgt_q   <= '0;
      cfg_q   <= '0;
      epend_q <= '0;
      irq_q   <= '0;
      sgi_q   <= '0;
    end else begin
      irq_q <= irq_in;
      for (int c = 0; c < NCPU; c++)
        for (int i = 0; i < N; i++)
          if (eoi_stb[c] && eoi_id[c*10 +: 10] == 10'(i)) act_q[i] <= 1'b0;
      for (int c = 0; c < NCPU; c++) begin
        for (int i = 0; i < N; i++)
          if (ack_stb[c] && ack_id[c*10 +: 10] == 10'(i)) act_q[i] <= 1'b1;
        for (int i = 0; i < 16; i++)
          if (ack_stb[c] && ack_id[c*10 +: 10] == 10'(i)) sgi_q[c][i] <= 1'b0;
        for (int j = 0; j < NEXT; j++)
          if (ack_stb[c] && ack_id[c*10 +: 10] == 10'(j + 16)) epend_q[j] <= 1'b0;
      end
      for (int j = 0; j < NEXT; j++)
        if (cfg_q[j] && irq_in[j] && !irq_q[j]) epend_q[j] <= 1'b1;
      if (bus_wr) begin
        if (wa == W_CTL) ctl_q <= bus_wdata[0];
        for (int i = 0; i < N; i++) begin
          if (wa == W_ESET + i/32 && bus_wdata[i%32]) ena_q[i] <= 1'b1;
          if (wa == W_ECLR + i/32 && bus_wdata[i%32]) ena_q[i] <= 1'b0;
          if (wa == W_PRIO + i/4) prio_q[i] <= bus_wdata[8*(i%4) +: 8];
        end
        for (int s = 0; s < NSPI; s++)
          if (wa == W_TGT + (s+32)/4) tgt_q[s] <= bus_wdata[8*(s%4) +: 8];
        for (int j = 0; j < NEXT; j++)
          if (wa == W_CFG + (j+16)/16) cfg_q[j] <= bus_wdata[2*((j+16)%16)+1];
        if (wa == W_SOFT)
          for (int c = 0; c < NCPU; c++)
            for (int i = 0; i < 16; i++)
              if (bus_wdata[16+c] && bus_wdata[3:0] == 4'(i)) sgi_q[c][i] <= 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (wa == W_CTL)  bus_rdata[0]   = ctl_q;
    if (wa == W_TYPE) bus_rdata[4:0] = 5'(NW - 1);
    for (int i = 0; i < N; i++) begin
      if (wa == W_ESET + i/32 || wa == W_ECLR + i/32) bus_rdata[i%32] = ena_q[i];
      if (wa == W_PRIO + i/4) bus_rdata[8*(i%4) +: 8] = prio_q[i];
    end
    for (int i = 0; i < 32; i++)
      if (wa == W_TGT + i/4) bus_rdata[8*(i%4) +: 8] = own_mask;
    for (int s = 0; s < NSPI; s++)
      if (wa == W_TGT + (s+32)/4) bus_rdata[8*(s%4) +: 8] = tgt_q[s];
    for (int i = 0; i < 16; i++)
      if (wa == W_CFG) bus_rdata[2*i+1] = 1'b1;
    for (int j = 0; j < NEXT; j++)
      if (wa == W_CFG + (j+16)/16) bus_rdata[2*((j+16)%16)+1] = cfg_q[j];
  end

  always_comb
    for (int c = 0; c < NCPU; c++) begin
      for (int i = 0; i < 16; i++) cand[c][i] = sgi_q[c][i];
      for (int j = 0; j < 16; j++) cand[c][j+16] = pend_ext[j];
      for (int s = 0; s < NSPI; s++) cand[c][s+32] = pend_ext[s+16] & tgt_q[s][c];
      cand[c] = cand[c] & ena_q & ~act_q & {N{ctl_q}};
    end

  always_comb
    for (int c = 0; c < NCPU; c++) begin
      bv[c] = 1'b0;
      bp[c] = 8'hFF;
      bi[c] = '0;
      for (int i = 0; i < N; i++)
        if (cand[c][i] && (!bv[c] || prio_q[i] < bp[c])) begin
          bv[c] = 1'b1;
          bp[c] = prio_q[i];
          bi[c] = 10'(i);
        end
      fwd_valid[c]         = bv[c];
      fwd_id[c*10 +: 10]   = bi[c];
      fwd_prio[c*8 +: 8]   = bp[c];
    end
endmodule

// File: rtl/irq_distributor_chk.sv
module irq_distributor_chk #(
  parameter int N    = 64,
  parameter int NCPU = 2,
  parameter int AW   = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_wr,
  input logic [AW-1:2]        bus_addr,
  input logic                 wdata0,
  input logic [31:0]          bus_rdata,
  input logic [NCPU-1:0]      fwd_valid,
  input logic [NCPU*10-1:0]   fwd_id,
  input logic [N-1:0]         ena_q,
  input logic [N-1:0]         act_q
);
  // R4
  ctl_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == '0 && !wdata0) |=> (fwd_valid == '0));

  // R5
  type_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == (AW-2)'(1)) |-> (bus_rdata == 32'(N/32 - 1)));

  // R12
  hole_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == (AW-2)'(2)) |-> (bus_rdata == 32'd0));

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [N-1:0] sel;
    assign sel = {{(N-1){1'b0}}, 1'b1} << fwd_id[c*10 +: 10];

    // R1
    fwd_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid[c] |-> ((ena_q & sel) != '0));

    // R13
    fwd_not_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid[c] |-> ((act_q & sel) == '0));
  end
endmodule

bind irq_distributor irq_distributor_chk #(.N(N), .NCPU(NCPU), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wdata0(bus_wdata[0]), .bus_rdata(bus_rdata), .fwd_valid(fwd_valid),
  .fwd_id(fwd_id), .ena_q(ena_q), .act_q(act_q)
);

// File: tb/tb_irq_distributor.sv
`timescale 1ns/1ps
module tb_irq_distributor;
  localparam int N = 64, NCPU = 2, AW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-17:0] irq_in = '0;
  logic bus_wr = 1'b0;
  logic [AW-1:2] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [0:0] bus_cpu = '0;
  logic [NCPU-1:0] ack_stb = '0, eoi_stb = '0, fwd_valid;
  logic [NCPU*10-1:0] ack_id = '0, eoi_id = '0, fwd_id;
  logic [NCPU*8-1:0] fwd_prio;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_distributor #(.N(N), .NCPU(NCPU), .AW(AW)) dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = (AW-2)'(a); bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0; #1;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk); bus_addr = (AW-2)'(a); #1; d = bus_rdata;
  endtask

  task automatic fwd(string tag, int c, logic v, int id);
    #1;
    chk({tag, " valid"}, 32'(fwd_valid[c]), 32'(v));
    if (v) chk({tag, " id"}, 32'(fwd_id[c*10 +: 10]), 32'(id));
  endtask

  task automatic ack(int c, int id);
    @(negedge clk); ack_stb[c] = 1'b1; ack_id[c*10 +: 10] = 10'(id);
    @(negedge clk); ack_stb = '0;
  endtask

  task automatic eoi(int c, int id);
    @(negedge clk); eoi_stb[c] = 1'b1; eoi_id[c*10 +: 10] = 10'(id);
    @(negedge clk); eoi_stb = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    fwd("R4 reset cpu0", 0, 1'b0, 0);
    fwd("R4 reset cpu1", 1, 1'b0, 0);
    rd(0, d);    chk("R4 ctl reset", d, 0);
    rd('h40, d); chk("R1 enable reset", d, 0);
  endtask

  task automatic t_type_hole;
    logic [31:0] d;
    rd(1, d); chk("R5 type", d, 32'(N/32 - 1));
    wr(1, 32'hFFFF_FFFF);
    rd(1, d); chk("R5 type after write", d, 32'(N/32 - 1));
    wr(2, 32'hFFFF_FFFF);
    rd(2, d); chk("R12 hole read", d, 0);
    rd(0, d); chk("R12 ctl untouched", d, 0);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wr('h40, 32'h0000_00F0); rd('h40, d); chk("R1 set", d, 32'h0000_00F0);
    wr('h40, 32'h0000_0001); rd('h40, d); chk("R1 set adds", d, 32'h0000_00F1);
    wr('h60, 32'h0000_0030); rd('h40, d); chk("R1 clear", d, 32'h0000_00C1);
    wr('h60, 32'h0);         rd('h60, d); chk("R1 zero no effect", d, 32'h0000_00C1);
    wr('h60, 32'hFFFF_FFFF); rd('h40, d); chk("R1 clear all", d, 0);
  endtask

  task automatic t_prio_tgt;
    logic [31:0] d;
    wr('h109, 32'h4433_2211); rd('h109, d); chk("R3 priority", d, 32'h4433_2211);
    wr('h20B, 32'h0804_0201); rd('h20B, d); chk("R3 target", d, 32'h0804_0201);
    wr('h200, 32'h0);
    bus_cpu = 1'b1; rd('h200, d); chk("R7 own mask cpu1", d, 32'h0202_0202);
    bus_cpu = 1'b0; rd('h207, d); chk("R7 own mask cpu0", d, 32'h0101_0101);
  endtask

  task automatic t_cfg;
    logic [31:0] d;
    wr('h300, 32'h0);
    rd('h300, d); chk("R2 sgi fixed", d, 32'hAAAA_AAAA);
    rd('h302, d); chk("R2 level reset", d, 0);
    wr('h302, 32'h0003_0000);
    rd('h302, d); chk("R2 edge id40", d, 32'h0002_0000);
  endtask

  task automatic t_level;
    logic [31:0] d;
    wr(0, 1); rd(0, d); chk("R4 ctl on", d, 1);
    wr('h108, 32'h0000_2000);
    wr('h208, 32'h0000_0100);
    wr('h41, 32'h0000_0002);
    @(negedge clk); irq_in[17] = 1'b1;
    fwd("R9 level cpu0", 0, 1'b1, 33);
    fwd("R11 not targeted cpu1", 1, 1'b0, 0);
    ack(0, 33); fwd("R13 active blocks", 0, 1'b0, 0);
    eoi(0, 33); fwd("R9 level after eoi", 0, 1'b1, 33);
    wr(0, 0);   fwd("R4 ctl off", 0, 1'b0, 0);
    wr(0, 1);   fwd("R4 ctl back on", 0, 1'b1, 33);
    @(negedge clk); irq_in[17] = 1'b0;
    fwd("R9 level low", 0, 1'b0, 0);
  endtask

  task automatic t_edge;
    wr('h10A, 32'h0000_0010);
    wr('h20A, 32'h0000_0003);
    wr('h41, 32'h0000_0100);
    @(negedge clk); irq_in[24] = 1'b1;
    @(negedge clk); irq_in[24] = 1'b0;
    fwd("R8 edge held cpu0", 0, 1'b1, 40);
    fwd("R8 edge held cpu1", 1, 1'b1, 40);
    ack(1, 40);
    fwd("R13 ack cpu0", 0, 1'b0, 0);
    fwd("R13 ack cpu1", 1, 1'b0, 0);
    eoi(1, 40);
    fwd("R8 no repend", 1, 1'b0, 0);
  endtask

  task automatic t_prio;
    wr('h208, 32'h0001_0100);
    wr('h108, 32'h0020_2000);
    wr('h41, 32'h0000_0004);
    @(negedge clk); irq_in[17] = 1'b1; irq_in[18] = 1'b1;
    fwd("R10 tie lower id", 0, 1'b1, 33);
    wr('h108, 32'h0010_2000);
    fwd("R10 lower value", 0, 1'b1, 34);
    chk("R10 fwd_prio", 32'(fwd_prio[7:0]), 32'h10);
    @(negedge clk); irq_in = '0;
    fwd("R9 all low", 0, 1'b0, 0);
  endtask

  task automatic t_sgi;
    wr('h40, 32'h0000_FFFF);
    wr('h3C0, 32'h0002_0005);
    fwd("R6 sgi cpu1", 1, 1'b1, 5);
    fwd("R11 sgi not cpu0", 0, 1'b0, 0);
    wr('h3C0, 32'h0003_0003);
    fwd("R6 sgi both cpu0", 0, 1'b1, 3);
    fwd("R6 sgi both cpu1", 1, 1'b1, 3);
    ack(1, 3);
    fwd("R13 sgi active cpu0", 0, 1'b0, 0);
    fwd("R6 sgi other cpu1", 1, 1'b1, 5);
    eoi(1, 3);
    fwd("R6 sgi kept cpu0", 0, 1'b1, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_type_hole;
    t_enable;
    t_prio_tgt;
    t_cfg;
    t_level;
    t_edge;
    t_prio;
    t_sgi;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule